// File: doc/BRIEF.md
# Key-Protected Peripheral Clock-Enable and Soft-Reset Register Bank

This block holds the per-peripheral clock enables and software reset controls of a subsystem in six 32-bit registers. There are three clock-enable registers and three soft-reset registers. Each register drives a 16-bit slice of a flat output vector. A clock-enable bit at 1 lets the peripheral clock run, and 0 stops it. A soft-reset bit at 1 holds the peripheral in reset, and 0 lets it run.

A register changes only when the write carries a 16-bit unlock key in the upper half of the write data. Any other write is dropped without a trace. The bank also holds a sticky lock flag. Once software sets it, the flag blocks writes to one configuration register that lives outside the bank. Only the block reset clears it.

Software uses a single-cycle register port. On a clock edge where the write enable is high, the port writes. Reads are combinational, so read data follows the address in the same cycle.

Top module: `pclk_rst_keybank`

## Requirements
- R1: Reset state. After reset every clock-enable output is 0, the lock flag is 0, and every soft-reset output is 0 except `rst_assert_o[16]` and `rst_assert_o[18]`. Those two are bits 0 and 2 of the second soft-reset register, and they start at 1.
- R2: A write changes a bank register only when `reg_wdata[31:16]` equals 16'h5634. With any other key value, no bit of the bank changes.
- R3: `reg_rdata[31:16]` always reads 0.
- R4: Only these writable bits exist: clock registers 16'h1111, 16'h0135 and 16'h0157; soft-reset registers 16'h1111, 16'h0135 and 16'h0140. Every other bit reads 0 and ignores writes, even when the key is correct.
- R5: The byte offsets are 0x00, 0x04 and 0x08 for the clock registers, 0x20, 0x24 and 0x28 for the soft-reset registers, and 0x30 for the lock. Any other address reads 0, and a write to it changes nothing.
- R6: `clk_en_o[16*i+b]` and `rst_assert_o[16*i+b]` equal bit b of clock register i and soft-reset register i. A write that is accepted shows on these outputs right after the clock edge that takes it.
- R7: Writing data with bit 0 = 1 to offset 0x30 sets the lock, and no key is needed. Writing 0 has no effect. The lock reads back at bit 0 of that offset, and it drives `ext_cfg_wr_block`. Only reset clears it.
- R8: Read data is combinational. In a cycle that writes an address, the read data still shows that address's value from before the write.
- R9: `rst_n` is active-low and synchronous. It takes effect at a clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data; bits 31:16 carry the key |
| reg_rdata | output | 32 | Combinational read data |
| clk_en_o | output | 48 | Peripheral clock enables, 16 bits per register |
| rst_assert_o | output | 48 | Peripheral reset asserts, 16 bits per register |
| ext_cfg_wr_block | output | 1 | Lock flag that blocks writes to the external configuration register |

## Verification
A single cycle can both read and write the same register through the one port. In that cycle the read must show the old contents, and the outputs must show the new contents only after the edge. The bench drives every write with the address held on the read path and checks the read data before the edge. It then checks the outputs and an ordinary read-back after the edge. The expected values come from a model whose key test and masks are written independently of the RTL. The writes mix correct and random keys, mapped and unmapped offsets, and lock set and clear attempts.

// File: rtl/pkb_pkg.sv
`timescale 1ns/1ps
package pkb_pkg;

  parameter int DATA_W  = 32;
  parameter int FIELD_W = 16;
  parameter int KEY_W   = DATA_W - FIELD_W;
  parameter int NUM_REG = 3;

  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h5634;

  // Writable bits of clock-enable register i
  function automatic logic [FIELD_W-1:0] clk_wmask(input int i);
    case (i)
      0:       return 16'h1111;
      1:       return 16'h0135;
      2:       return 16'h0157;
      default: return '0;
    endcase
  endfunction

  // Writable bits of soft-reset register i
  function automatic logic [FIELD_W-1:0] rst_wmask(input int i);
    case (i)
      0:       return 16'h1111;
      1:       return 16'h0135;
      2:       return 16'h0140;
      default: return '0;
    endcase
  endfunction

  // Value of soft-reset register i after reset
  function automatic logic [FIELD_W-1:0] rst_init(input int i);
    case (i)
      1:       return 16'h0005;
      default: return '0;
    endcase
  endfunction

  function automatic logic key_ok(input logic [DATA_W-1:0] d);
    return d[DATA_W-1:FIELD_W] == UNLOCK_KEY;
  endfunction

  function automatic logic [FIELD_W-1:0] merge_bits(
      input logic [FIELD_W-1:0] old_v,
      input logic [FIELD_W-1:0] new_v,
      input logic [FIELD_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/pkb_addr_dec.sv
`timescale 1ns/1ps
module pkb_addr_dec #(
  parameter int ADDR_W   = 12,
  parameter int NREG     = 3,
  parameter int CLK_BASE = 'h00,
  parameter int RST_BASE = 'h20,
  parameter int LOCK_OFS = 'h30
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   clk_hit,
  output logic [NREG-1:0]   rst_hit,
  output logic              lock_hit,
  output logic              any_hit
);
  localparam int STRIDE = 4;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] CLK_A = ADDR_W'(CLK_BASE + STRIDE * i);
    localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RST_BASE + STRIDE * i);
    assign clk_hit[i] = (addr == CLK_A);
    assign rst_hit[i] = (addr == RST_A);
  end

  assign lock_hit = (addr == ADDR_W'(LOCK_OFS));
  assign any_hit  = (|clk_hit) | (|rst_hit) | lock_hit;
endmodule

// File: rtl/pkb_keyreg.sv
`timescale 1ns/1ps
module pkb_keyreg #(
  parameter int              FW   = 16,
  parameter logic [FW-1:0]   MASK = '1,
  parameter logic [FW-1:0]   INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] q
);
  localparam logic [FW-1:0] INIT_M = INIT & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= INIT_M;
    else if (wr_stb) q <= (q & ~MASK) | (wdata & MASK);
  end
endmodule

// File: rtl/pkb_lock.sv
`timescale 1ns/1ps
module pkb_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end
endmodule

// File: rtl/pclk_rst_keybank.sv
`timescale 1ns/1ps
module pclk_rst_keybank
  import pkb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NREG     = NUM_REG,
  parameter int CLK_BASE = 'h00,
  parameter int RST_BASE = 'h20,
  parameter int LOCK_OFS = 'h30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr_en,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [NREG*FIELD_W-1:0] clk_en_o,
  output logic [NREG*FIELD_W-1:0] rst_assert_o,
  output logic                    ext_cfg_wr_block
);
  localparam int FW = FIELD_W;

  logic [NREG-1:0] clk_hit, rst_hit;
  logic            lock_hit, any_hit;
  logic            key_match, wr_accept, lock_set;
  logic [FW-1:0]   clk_q [NREG];
  logic [FW-1:0]   rst_q [NREG];
  logic            locked;

  pkb_addr_dec #(
    .ADDR_W(ADDR_W), .NREG(NREG),
    .CLK_BASE(CLK_BASE), .RST_BASE(RST_BASE), .LOCK_OFS(LOCK_OFS)
  ) u_dec (
    .addr(reg_addr), .clk_hit(clk_hit), .rst_hit(rst_hit),
    .lock_hit(lock_hit), .any_hit(any_hit)
  );

  assign key_match = key_ok(reg_wdata);
  assign wr_accept = reg_wr_en & key_match;
  assign lock_set  = reg_wr_en & lock_hit & reg_wdata[0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    pkb_keyreg #(.FW(FW), .MASK(clk_wmask(i)), .INIT('0)) u_clk (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_accept & clk_hit[i]),
      .wdata(reg_wdata[FW-1:0]), .q(clk_q[i])
    );
    pkb_keyreg #(.FW(FW), .MASK(rst_wmask(i)), .INIT(rst_init(i))) u_rst (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_accept & rst_hit[i]),
      .wdata(reg_wdata[FW-1:0]), .q(rst_q[i])
    );
    assign clk_en_o[i*FW +: FW]     = clk_q[i];
    assign rst_assert_o[i*FW +: FW] = rst_q[i];
  end

  pkb_lock u_lock (
    .clk(clk), .rst_n(rst_n), .set_req(lock_set), .locked(locked)
  );
  assign ext_cfg_wr_block = locked;

  // Combinational read; key half never driven
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (clk_hit[i]) reg_rdata[FW-1:0] = clk_q[i];
      if (rst_hit[i]) reg_rdata[FW-1:0] = rst_q[i];
    end
    if (lock_hit) reg_rdata[0] = locked;
  end
endmodule

// File: rtl/pkb_checker.sv
`timescale 1ns/1ps
module pkb_checker
  import pkb_pkg::*;
#(
  parameter int NREG = NUM_REG
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr_en,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [NREG*FIELD_W-1:0] clk_en_o,
  input logic [NREG*FIELD_W-1:0] rst_assert_o,
  input logic                    ext_cfg_wr_block,
  input logic                    any_hit,
  input logic                    clk_hit0
);
  localparam int FW = FIELD_W;

  // R3
  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:FW] == '0);

  // R2
  a_r2_bad_key_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[DATA_W-1:FW] != UNLOCK_KEY)
      |=> ($stable(clk_en_o) && $stable(rst_assert_o)));

  // R5
  a_r5_unmapped_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !any_hit)
      |=> ($stable(clk_en_o) && $stable(rst_assert_o) && $stable(ext_cfg_wr_block)));

  // R7
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cfg_wr_block |=> ext_cfg_wr_block);

  // R6
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && clk_hit0 && reg_wdata[DATA_W-1:FW] == UNLOCK_KEY)
      |=> clk_en_o[FW-1:0] == ($past(reg_wdata[FW-1:0]) & clk_wmask(0)));

  for (genvar i = 0; i < NREG; i++) begin : g_res
    // R4
    a_r4_reserved_clk_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_o[i*FW +: FW] & ~clk_wmask(i)) == '0);
    a_r4_reserved_rst_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_assert_o[i*FW +: FW] & ~rst_wmask(i)) == '0);
  end
endmodule

bind pclk_rst_keybank pkb_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .clk_en_o(clk_en_o), .rst_assert_o(rst_assert_o),
  .ext_cfg_wr_block(ext_cfg_wr_block), .any_hit(any_hit), .clk_hit0(clk_hit[0])
);

// File: tb/sim_pclk_rst_keybank.sv
`timescale 1ns/1ps
module sim_pclk_rst_keybank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] clk_en_o, rst_assert_o;
  logic        ext_cfg_wr_block;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [15:0] m_clk [3];
  logic [15:0] m_rst [3];
  logic        m_lock;

  pclk_rst_keybank u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o),
    .rst_assert_o(rst_assert_o), .ext_cfg_wr_block(ext_cfg_wr_block)
  );

  always #10 clk = ~clk;

  // Writable-bit tables restated from R4 as bit positions
  function automatic logic [15:0] b_mask(input bit is_rst, input int i);
    logic [15:0] m = '0;
    if (i == 0) begin m[0] = 1; m[4] = 1; m[8] = 1; m[12] = 1; end
    if (i == 1) begin m[0] = 1; m[2] = 1; m[4] = 1; m[5] = 1; m[8] = 1; end
    if (i == 2 && !is_rst) begin m[0] = 1; m[1] = 1; m[2] = 1; m[4] = 1; m[6] = 1; m[8] = 1; end
    if (i == 2 && is_rst) begin m[6] = 1; m[8] = 1; end
    return m;
  endfunction

  function automatic logic [31:0] b_read(input logic [11:0] a);
    for (int i = 0; i < 3; i++) begin
      if (a == 12'(4 * i))        return {16'h0, m_clk[i]};
      if (a == 12'(32 + 4 * i))   return {16'h0, m_rst[i]};
    end
    if (a == 12'h030) return {31'h0, m_lock};
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_clk[i] = '0; m_rst[i] = '0; end
    m_rst[1] = 16'h0005;
    m_lock = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req);
    check({req, " clk_en"}, 64'(clk_en_o), 64'({m_clk[2], m_clk[1], m_clk[0]}));
    check({req, " rst"}, 64'(rst_assert_o), 64'({m_rst[2], m_rst[1], m_rst[0]}));
    check({req, " lock"}, 64'(ext_cfg_wr_block), 64'(m_lock));
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    @(negedge clk);
    reg_addr = a; reg_wr_en = 1'b0;
    #1 check(req, 64'(reg_rdata), 64'(b_read(a)));
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    #1 check("R8 read during write shows old value", 64'(reg_rdata), 64'(b_read(a)));
    @(posedge clk);
    if (d[31:16] == 16'h5634) begin
      for (int i = 0; i < 3; i++) begin
        if (a == 12'(4 * i))
          m_clk[i] = (m_clk[i] & ~b_mask(0, i)) | (d[15:0] & b_mask(0, i));
        if (a == 12'(32 + 4 * i))
          m_rst[i] = (m_rst[i] & ~b_mask(1, i)) | (d[15:0] & b_mask(1, i));
      end
    end
    if (a == 12'h030 && d[0]) m_lock = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1 check_outs(req);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 3; i++) begin
      do_read(12'(4 * i), req);
      do_read(12'(32 + 4 * i), req);
    end
    do_read(12'h030, req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check_outs("R9 no effect before edge");
    @(posedge clk);
    model_reset();
    @(negedge clk);
    #1 check_outs("R1 reset state");
    rst_n = 1'b1;
  endtask

  initial begin
    logic [11:0] addrs [8];
    void'($urandom(32'd20240611));
    addrs[0] = 12'h000; addrs[1] = 12'h004; addrs[2] = 12'h008; addrs[3] = 12'h020;
    addrs[4] = 12'h024; addrs[5] = 12'h028; addrs[6] = 12'h030; addrs[7] = 12'h00C;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check_outs("R1 reset state");
    check("R1 rst bit16", 64'(rst_assert_o[16]), 64'd1);
    check("R1 rst bit18", 64'(rst_assert_o[18]), 64'd1);
    rst_n = 1'b1;
    read_all("R1 R5 reset readback");

    // R2 wrong key keeps state
    do_write(12'h024, 32'h5635_0000, "R2 wrong key");
    do_write(12'h000, 32'h0000_FFFF, "R2 zero key");
    // R4 correct key, reserved bits stay 0
    do_write(12'h000, 32'h5634_FFFF, "R4 reserved bits clk0");
    do_write(12'h028, 32'h5634_FFFF, "R4 reserved bits rst2");
    do_write(12'h024, 32'h5634_0000, "R6 release held resets");
    read_all("R3 R4 readback");
    // R5 unmapped and misaligned
    do_write(12'h00C, 32'h5634_FFFF, "R5 unmapped write");
    do_write(12'h002, 32'h5634_0000, "R5 misaligned write");
    do_read(12'h00C, "R5 unmapped read");
    do_read(12'hFFC, "R5 unmapped read high");
    // R7 lock
    do_write(12'h030, 32'h5634_0000, "R7 writing 0 no effect");
    do_write(12'h030, 32'h0000_0001, "R7 set without key");
    do_write(12'h030, 32'h5634_0000, "R7 sticky");
    do_read(12'h030, "R7 lock readback");

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ($urandom % 10 == 0) ? 12'($urandom) : addrs[$urandom % 8];
      d = $urandom;
      if ($urandom % 2 == 0) d[31:16] = 16'h5634;
      if (a == 12'h030 && $urandom % 4 != 0) d[0] = 1'b0;
      do_write(a, d, "R2 R6 random write");
      if (k % 5 == 0) do_read(addrs[$urandom % 8], "R3 R5 random read");
    end

    apply_reset();
    read_all("R1 R7 after second reset");
    do_write(12'h020, 32'h5634_1111, "R6 write after reset");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule